// File: doc/BRIEF.md
# Serial I/O Port Address Capture

This block grabs the 8-bit port number that a CPU drives onto its low address lines during an I/O request. It hands that number to a host controller one bit at a time on a single serial line, so the host needs one data pin instead of eight. A parallel-in/serial-out register does the capture. Its load/shift mode comes from one line that the host also uses as the CPU clock. While that line is low, the register keeps reloading the address lines. While it is high, each pulse of a separate shift strobe moves the register one place toward the output. The most significant address bit comes out first.

The register's serial input is tied to the raw machine-cycle-one status line. After eight shifts, a ninth bit appears on the output, and that bit tells the host whether the cycle was an interrupt acknowledge or a real port access.

At every load the block also decodes the address. The upper half of the port space belongs to the host. Inside that half, two address bits pick one of four host devices. The hit flag and the device select are registered at capture time and are held unchanged until the next load. The lower half of the port space is never claimed, so other peripherals on the CPU bus can use it.

Top module: `ioport_serial_capture`

## Requirements
- R1: While `rst` is high, and on the first edge after it is applied, `ser_out`, `host_hit` and `dev_sel` are all 0.
- R2: On each clock edge with `clk_mode` low, the register loads `addr_lo`. After that edge, `ser_out` equals `addr_lo[7]`.
- R3: On each clock edge with `clk_mode` high and `shift_stb` high, the register shifts one place toward the output. After k shifts (1 to 7), `ser_out` equals `addr_lo[7-k]` of the loaded value.
- R4: The register's serial input is the raw level of `fetch_n` (1 = not a machine-cycle-one). After 8 shifts, `ser_out` carries the `fetch_n` level that was present on the first shift. This is the ninth bit.
- R5: With `clk_mode` high and `shift_stb` low, the register holds, and `ser_out` does not change whatever the address lines do.
- R6: A load with `io_req_n` = 0, `fetch_n` = 1 and `addr_lo[7]` = 1 (ports 0x80 to 0xFF) sets `host_hit` to 1.
- R7: A load of any address with `addr_lo[7]` = 0 (ports 0x00 to 0x7F) sets `host_hit` to 0.
- R8: A load with `io_req_n` = 0 and `fetch_n` = 0 is an interrupt acknowledge and sets `host_hit` to 0 for any address.
- R9: On a load that hits, `dev_sel` takes `addr_lo[6:5]`. On a load that does not hit, `dev_sel` is 0.
- R10: While `clk_mode` is high, `host_hit` and `dev_sel` keep the values from the last load, whatever the inputs do.
- R11: A load with `io_req_n` = 1 sets `host_hit` to 0. The address is still loaded into the register.
- R12: With `clk_mode` low, loading takes priority over `shift_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| io_req_n | input | 1 | CPU I/O request strobe, active low |
| addr_lo | input | 8 | CPU low address lines carrying the port number |
| fetch_n | input | 1 | CPU machine-cycle-one status, active low; also the register's serial input |
| clk_mode | input | 1 | Shared CPU clock / mode line: low = load, high = shift enabled |
| shift_stb | input | 1 | Shift strobe; one shift per clock it is high while `clk_mode` is high |
| ser_out | output | 1 | Serial output, the register's most significant bit |
| host_hit | output | 1 | Captured port belongs to the host |
| dev_sel | output | 2 | Captured host device number |

## Verification
The bound assertions check several rules on every cycle:
- After any load, the serial output equals the top address bit.
- A held register does not move.
- Lower-half ports and interrupt acknowledges never raise the hit flag.
- The device select is zero whenever there is no hit.
- The hit flag and select stay frozen while the mode line is high.

Some behaviour only shows across a whole sequence, so the directed scenarios cover it:
- the full most-significant-first bit order over eight shifts;
- the ninth bit carrying the machine-cycle-one level;
- the priority of load over the strobe;
- the decoding of each of the four devices.

// File: rtl/iocap_pkg.sv
package iocap_pkg;

  // Operation applied to the capture register on a clock edge
  typedef enum logic [1:0] {
    CAP_HOLD  = 2'd0,
    CAP_LOAD  = 2'd1,
    CAP_SHIFT = 2'd2
  } cap_op_e;

endpackage

// File: rtl/iocap_ctrl.sv
module iocap_ctrl
  import iocap_pkg::*;
(
  input  logic    clk_mode,
  input  logic    shift_stb,
  output cap_op_e op
);

  // Low mode line forces a load; a strobe only counts while the line is high
  always_comb begin
    if (!clk_mode)      op = CAP_LOAD;
    else if (shift_stb) op = CAP_SHIFT;
    else                op = CAP_HOLD;
  end

endmodule

// File: rtl/iocap_piso.sv
module iocap_piso
  import iocap_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  cap_op_e      op,
  input  logic [W-1:0] par_in,
  input  logic         ser_in,
  output logic         ser_out
);

  logic [W-1:0] q;
  logic [W-1:0] shift_src;

  // Each cell takes its lower neighbour on a shift; the bottom cell takes the serial input
  assign shift_src = {q[W-2:0], ser_in};

  for (genvar i = 0; i < W; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst) begin
        q[i] <= 1'b0;
      end else begin
        unique case (op)
          CAP_LOAD:  q[i] <= par_in[i];
          CAP_SHIFT: q[i] <= shift_src[i];
          default:   q[i] <= q[i];
        endcase
      end
    end
  end

  assign ser_out = q[W-1];

endmodule

// File: rtl/iocap_decode.sv
module iocap_decode
  import iocap_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SEL_LO = 5,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  cap_op_e           op,
  input  logic [ADDR_W-1:0] addr,
  input  logic              io_req_n,
  input  logic              fetch_n,
  output logic              host_hit,
  output logic [SEL_W-1:0]  dev_sel
);

  localparam int HIT_BIT = ADDR_W - 1;

  logic             hit_d;
  logic [SEL_W-1:0] sel_d;

  // A port access (not an interrupt acknowledge) into the upper half
  assign hit_d = !io_req_n && fetch_n && addr[HIT_BIT];
  assign sel_d = hit_d ? addr[SEL_LO +: SEL_W] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      host_hit <= 1'b0;
      dev_sel  <= '0;
    end else if (op == CAP_LOAD) begin
      host_hit <= hit_d;
      dev_sel  <= sel_d;
    end
  end

endmodule

// File: rtl/ioport_serial_capture.sv
module ioport_serial_capture
  import iocap_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SEL_LO = 5,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_req_n,
  input  logic [ADDR_W-1:0] addr_lo,
  input  logic              fetch_n,
  input  logic              clk_mode,
  input  logic              shift_stb,
  output logic              ser_out,
  output logic              host_hit,
  output logic [SEL_W-1:0]  dev_sel
);

  cap_op_e op;

  iocap_ctrl u_ctrl (
    .clk_mode  (clk_mode),
    .shift_stb (shift_stb),
    .op        (op)
  );

  // The machine-cycle-one line feeds the serial input: it supplies the ninth bit
  iocap_piso #(.W(ADDR_W)) u_piso (
    .clk     (clk),
    .rst     (rst),
    .op      (op),
    .par_in  (addr_lo),
    .ser_in  (fetch_n),
    .ser_out (ser_out)
  );

  iocap_decode #(.ADDR_W(ADDR_W), .SEL_LO(SEL_LO), .SEL_W(SEL_W)) u_dec (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .addr     (addr_lo),
    .io_req_n (io_req_n),
    .fetch_n  (fetch_n),
    .host_hit (host_hit),
    .dev_sel  (dev_sel)
  );

endmodule

// File: rtl/ioport_serial_capture_chk.sv
module ioport_serial_capture_chk #(
  parameter int ADDR_W = 8,
  parameter int SEL_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              io_req_n,
  input logic [ADDR_W-1:0] addr_lo,
  input logic              fetch_n,
  input logic              clk_mode,
  input logic              shift_stb,
  input logic              ser_out,
  input logic              host_hit,
  input logic [SEL_W-1:0]  dev_sel
);

  // R1: reset clears every output on the next edge
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!ser_out && !host_hit && dev_sel == '0));

  // R2: a load exposes the top address bit
  a_r2_load_msb: assert property (@(posedge clk) disable iff (rst)
    !clk_mode |=> ser_out == $past(addr_lo[ADDR_W-1]));

  // R5: no strobe with the mode line high means no movement
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (clk_mode && !shift_stb) |=> $stable(ser_out));

  // R7: lower-half ports are never claimed
  a_r7_low_half: assert property (@(posedge clk) disable iff (rst)
    (!clk_mode && !addr_lo[ADDR_W-1]) |=> !host_hit);

  // R8: interrupt acknowledge is never a host hit
  a_r8_int_ack: assert property (@(posedge clk) disable iff (rst)
    (!clk_mode && !fetch_n) |=> !host_hit);

  // R11: no I/O request, no hit
  a_r11_no_req: assert property (@(posedge clk) disable iff (rst)
    (!clk_mode && io_req_n) |=> !host_hit);

  // R9: the select is zero without a hit
  a_r9_sel_zero: assert property (@(posedge clk) disable iff (rst)
    !host_hit |-> dev_sel == '0);

  // R10: decode results are frozen while the mode line is high
  a_r10_freeze: assert property (@(posedge clk) disable iff (rst)
    clk_mode |=> ($stable(host_hit) && $stable(dev_sel)));

endmodule

bind ioport_serial_capture ioport_serial_capture_chk #(
  .ADDR_W(ADDR_W), .SEL_W(SEL_W)
) u_chk (
  .clk(clk), .rst(rst), .io_req_n(io_req_n), .addr_lo(addr_lo),
  .fetch_n(fetch_n), .clk_mode(clk_mode), .shift_stb(shift_stb),
  .ser_out(ser_out), .host_hit(host_hit), .dev_sel(dev_sel)
);

// File: tb/ioport_serial_capture_tb.sv
`timescale 1ns/1ps
module ioport_serial_capture_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       io_req_n = 1'b1;
  logic [7:0] addr_lo = 8'h00;
  logic       fetch_n = 1'b1;
  logic       clk_mode = 1'b0;
  logic       shift_stb = 1'b0;
  logic       ser_out;
  logic       host_hit;
  logic [1:0] dev_sel;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  ioport_serial_capture u_dut (
    .clk(clk), .rst(rst), .io_req_n(io_req_n), .addr_lo(addr_lo),
    .fetch_n(fetch_n), .clk_mode(clk_mode), .shift_stb(shift_stb),
    .ser_out(ser_out), .host_hit(host_hit), .dev_sel(dev_sel)
  );

  task automatic check(input string req, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // Inputs are driven at a falling edge; one rising edge; sample at the next falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load(input logic [7:0] a, input logic req_n, input logic f_n);
    addr_lo = a; io_req_n = req_n; fetch_n = f_n;
    clk_mode = 1'b0; shift_stb = 1'b0;
    step();
    clk_mode = 1'b1;
  endtask

  task automatic shift1();
    shift_stb = 1'b1;
    step();
    shift_stb = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; addr_lo = 8'hFF; io_req_n = 1'b0; clk_mode = 1'b0;
    step(); step();
    check("R1 ser_out", ser_out, 0);
    check("R1 host_hit", host_hit, 0);
    check("R1 dev_sel", dev_sel, 0);
    rst = 1'b0; clk_mode = 1'b1;
    step();
  endtask

  task automatic t_stream(input logic [7:0] a, input logic f_n);
    load(a, 1'b0, f_n);
    check("R2 load msb", ser_out, a[7]);
    for (int k = 1; k < 8; k++) begin
      shift1();
      check("R3 bit order", ser_out, a[7-k]);
    end
    shift1();
    check("R4 ninth bit", ser_out, f_n);
  endtask

  task automatic t_decode();
    for (int d = 0; d < 4; d++) begin
      load(8'h80 | 8'(d << 5) | 8'h0B, 1'b0, 1'b1);
      check("R6 hit", host_hit, 1);
      check("R9 select", dev_sel, d);
    end
    load(8'h7F, 1'b0, 1'b1);
    check("R7 low half hit", host_hit, 0);
    check("R9 select on miss", dev_sel, 0);
    load(8'h00, 1'b0, 1'b1);
    check("R7 port zero", host_hit, 0);
    load(8'hE0, 1'b0, 1'b0);
    check("R8 int ack hit", host_hit, 0);
    check("R8 int ack select", dev_sel, 0);
    load(8'hC0, 1'b1, 1'b1);
    check("R11 no request hit", host_hit, 0);
    check("R11 address still loaded", ser_out, 1);
  endtask

  task automatic t_hold();
    load(8'hE0, 1'b0, 1'b1);
    for (int k = 0; k < 4; k++) begin
      addr_lo = 8'(k * 8'h13); io_req_n = 1'b1; fetch_n = 1'b0;
      step();
      check("R5 held ser_out", ser_out, 1);
      check("R10 held hit", host_hit, 1);
      check("R10 held select", dev_sel, 3);
    end
    fetch_n = 1'b1;
    shift1(); shift1(); shift1();
    check("R5 after shifts", ser_out, 0);
    check("R10 hit during shift", host_hit, 1);
  endtask

  task automatic t_priority();
    load(8'hFF, 1'b0, 1'b1);
    addr_lo = 8'h40; clk_mode = 1'b0; shift_stb = 1'b1;
    step();
    shift_stb = 1'b0; clk_mode = 1'b1;
    check("R12 load wins msb", ser_out, 0);
    check("R12 load wins hit", host_hit, 0);
    shift1();
    check("R12 next bit", ser_out, 1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_stream(8'hA5, 1'b1);
    t_stream(8'h3C, 1'b0);
    t_stream(8'hFF, 1'b1);
    t_stream(8'h01, 1'b0);
    t_decode();
    t_hold();
    t_priority();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule